// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Modulator

This block produces the four gate-drive commands for a full-bridge power stage: a high-side and a low-side command for each of two legs, called leg A and leg B. Each leg alternates its two switches with a fixed 50% duty cycle. A free-running period counter sets the switching frequency. Leg A is the reference and leg B is delayed from it by a phase offset counted in clock cycles. Energy reaches the transformer only while the high side of one leg conducts together with the low side of the other. A zero offset therefore transfers no power, and an offset of half a period transfers the most.

Two digital demand words, one from a current loop and one from a voltage loop, ask for a phase offset. The smaller of the two wins, is limited to half a period, and is latched only when the counter wraps. A steady period therefore never changes its shape halfway through. A flag shows which loop won at the last latch. Every leg passes through a dead-time stage that keeps both switches of the leg off for a programmable time around each change. A global enable turns all four commands off at the next clock edge.

Top module: `psfb_mod`

## Requirements
- R1: While `rst` is high at a clock edge, all four gate outputs and `volt_in_ctrl` are 0 after that edge. The counter, the latched period, the latched phase and the dead-time state are also cleared.
- R2: With `en` high, the counter runs from 0 to the latched period value Pm and then wraps to 0, so a period lasts P = Pm+1 cycles. The leg A drive signal is 1 for counts below floor(P/2) and 0 for the other counts.
- R3: The leg B drive signal is 1 when ((count - ph) mod P) < floor(P/2), where ph is the latched phase.
- R4: The latched phase is min(dem_cur, dem_volt), limited to floor(P/2). A phase of 0 makes legs A and B identical, so `a_hi` and `b_lo` are never high together. A phase of P/2 with P=16 and dead time 0 gives 7 such overlap cycles per period.
- R5: `volt_in_ctrl` is 1 when dem_volt < dem_cur and 0 otherwise, so the current loop keeps control on a tie. It is latched together with the phase.
- R6: `period_m1`, `dem_cur` and `dem_volt` are sampled only in a cycle where the counter wraps or `en` is low. A change at any other time has no effect until the next wrap.
- R7: In each leg the outputs follow the drive signal one clock later, as hi=drive and lo=not drive. When the drive signal changes, both outputs of that leg are 0 for dead_cyc+1 cycles. The high and low outputs of one leg are never 1 together.
- R8: An edge with `en` low makes all four outputs 0 after that edge, and the counter returns to 0. After `en` rises again, each leg keeps both outputs at 0 for dead_cyc cycles before it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low forces all gate outputs off |
| period_m1 | input | 8 | Switching period in cycles minus one |
| dead_cyc | input | 4 | Dead time in cycles (blanking lasts dead_cyc+1) |
| dem_cur | input | 8 | Phase demand from the current loop, in cycles |
| dem_volt | input | 8 | Phase demand from the voltage loop, in cycles |
| a_hi | output | 1 | Leg A high-side gate command |
| a_lo | output | 1 | Leg A low-side gate command |
| b_hi | output | 1 | Leg B high-side gate command |
| b_lo | output | 1 | Leg B low-side gate command |
| volt_in_ctrl | output | 1 | 1 when the voltage loop set the latched phase |

## Verification
The hardest case to reach from the ports is a demand or period change that arrives partway through a period and must be ignored until the next wrap. It must also land near a leg transition that is still inside its dead-time window. The random stimulus changes period, dead time and both demands at random intervals that are not tied to the period, so many changes fall mid-period. Directed segments then set exact full-overlap and zero-overlap phases and drop the enable while a leg is driving.

// File: rtl/psfb_pkg.sv
`timescale 1ns/100ps
package psfb_pkg;
  // Which demand source won the last phase latch.
  typedef enum logic {
    LOOP_CURRENT = 1'b0,
    LOOP_VOLTAGE = 1'b1
  } loop_e;

  // Indexes of the two legs in generated arrays.
  localparam int LEG_A = 0;
  localparam int LEG_B = 1;
  localparam int NUM_LEGS = 2;
endpackage

// File: rtl/psfb_dem_sel.sv
`timescale 1ns/100ps
module psfb_dem_sel
  import psfb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] dem_cur,
  input  logic [CNT_W-1:0] dem_volt,
  output logic [CNT_W-1:0] dem_min,
  output loop_e            winner
);
  // The smaller demand asks for less overlap and so takes control.
  always_comb begin
    if (dem_volt < dem_cur) begin
      dem_min = dem_volt;
      winner  = LOOP_VOLTAGE;
    end else begin
      dem_min = dem_cur;
      winner  = LOOP_CURRENT;
    end
  end
endmodule

// File: rtl/psfb_timebase.sv
`timescale 1ns/100ps
module psfb_timebase
  import psfb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period_m1,
  input  logic [CNT_W-1:0] dem_min,
  input  loop_e            winner,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] ph,
  output loop_e            loop_q
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] half_next;
  logic [EXT_W-1:0] half_cur;
  logic [CNT_W-1:0] ph_next;
  logic             wrap;

  assign half_next = ({1'b0, period_m1} + EXT_W'(1)) >> 1;
  assign half_cur  = ({1'b0, per_q} + EXT_W'(1)) >> 1;
  assign ph_next   = ({1'b0, dem_min} < half_next) ? dem_min : half_next[CNT_W-1:0];
  assign wrap      = !en || (cnt >= per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      per_q  <= '0;
      ph     <= '0;
      loop_q <= LOOP_CURRENT;
    end else if (wrap) begin
      cnt    <= '0;
      per_q  <= period_m1;
      ph     <= ph_next;
      loop_q <= winner;
    end else begin
      cnt    <= cnt + CNT_W'(1);
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_q);

  p_phase_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ph} <= half_cur);

  p_latch_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> ($stable(ph) && $stable(per_q) && $stable(loop_q)));
endmodule

// File: rtl/psfb_leg.sv
`timescale 1ns/100ps
module psfb_leg #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            drive,
  input  logic [DT_W-1:0] dead_cyc,
  output logic            hi,
  output logic            lo
);
  logic            drive_q;
  logic [DT_W-1:0] dt_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi      <= 1'b0;
      lo      <= 1'b0;
      drive_q <= 1'b0;
      dt_cnt  <= '0;
    end else if (!en) begin
      hi      <= 1'b0;
      lo      <= 1'b0;
      drive_q <= drive;
      dt_cnt  <= dead_cyc;
    end else if (drive != drive_q) begin
      hi      <= 1'b0;
      lo      <= 1'b0;
      drive_q <= drive;
      dt_cnt  <= dead_cyc;
    end else if (dt_cnt != '0) begin
      hi      <= 1'b0;
      lo      <= 1'b0;
      dt_cnt  <= dt_cnt - DT_W'(1);
    end else begin
      hi      <= drive;
      lo      <= !drive;
    end
  end

  p_no_shoot_r7: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));

  p_hi_break_make_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(hi) |-> !$past(lo));

  p_lo_break_make_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lo) |-> !$past(hi));

  p_disable_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hi && !lo));
endmodule

// File: rtl/psfb_mod.sv
`timescale 1ns/100ps
module psfb_mod
  import psfb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period_m1,
  input  logic [DT_W-1:0]  dead_cyc,
  input  logic [CNT_W-1:0] dem_cur,
  input  logic [CNT_W-1:0] dem_volt,
  output logic             a_hi,
  output logic             a_lo,
  output logic             b_hi,
  output logic             b_lo,
  output logic             volt_in_ctrl
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0]    dem_min;
  loop_e               winner;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    per_q;
  logic [CNT_W-1:0]    ph;
  loop_e               loop_q;
  logic [EXT_W-1:0]    per_len;
  logic [EXT_W-1:0]    half_len;
  logic [EXT_W-1:0]    shifted;
  logic [NUM_LEGS-1:0] drive;
  logic [NUM_LEGS-1:0] leg_hi;
  logic [NUM_LEGS-1:0] leg_lo;

  psfb_dem_sel #(.CNT_W(CNT_W)) u_sel (
    .dem_cur (dem_cur),
    .dem_volt(dem_volt),
    .dem_min (dem_min),
    .winner  (winner)
  );

  psfb_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .period_m1(period_m1),
    .dem_min  (dem_min),
    .winner   (winner),
    .cnt      (cnt),
    .per_q    (per_q),
    .ph       (ph),
    .loop_q   (loop_q)
  );

  // Leg A is the reference square wave; leg B is the same wave delayed by ph.
  always_comb begin
    per_len  = {1'b0, per_q} + EXT_W'(1);
    half_len = per_len >> 1;
    if (cnt >= ph) shifted = {1'b0, cnt} - {1'b0, ph};
    else           shifted = {1'b0, cnt} + per_len - {1'b0, ph};
    drive[LEG_A] = ({1'b0, cnt} < half_len);
    drive[LEG_B] = (shifted < half_len);
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg #(.DT_W(DT_W)) u_leg (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .drive   (drive[g]),
      .dead_cyc(dead_cyc),
      .hi      (leg_hi[g]),
      .lo      (leg_lo[g])
    );
  end

  assign a_hi         = leg_hi[LEG_A];
  assign a_lo         = leg_lo[LEG_A];
  assign b_hi         = leg_hi[LEG_B];
  assign b_lo         = leg_lo[LEG_B];
  assign volt_in_ctrl = (loop_q == LOOP_VOLTAGE);

  // R4: a zero phase keeps the two legs in step, so no diagonal pair conducts.
  p_zero_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (ph == '0) |-> (drive[LEG_A] == drive[LEG_B]));
endmodule

// File: tb/psfb_mod_tb.sv
`timescale 1ns/100ps
module psfb_mod_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] period_m1 = 8'd15;
  logic [3:0] dead_cyc = 4'd0;
  logic [7:0] dem_cur = 8'd0;
  logic [7:0] dem_volt = 8'd0;
  logic a_hi, a_lo, b_hi, b_lo, volt_in_ctrl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state (next values predicted from the requirements).
  int m_cnt, m_per, m_ph, m_v;
  int m_rq[2], m_dc[2], m_hi[2], m_lo[2];

  always #2.5 clk = ~clk;

  psfb_mod dut_i (
    .clk(clk), .rst(rst), .en(en), .period_m1(period_m1), .dead_cyc(dead_cyc),
    .dem_cur(dem_cur), .dem_volt(dem_volt), .a_hi(a_hi), .a_lo(a_lo),
    .b_hi(b_hi), .b_lo(b_lo), .volt_in_ctrl(volt_in_ctrl)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int min2(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  task automatic leg_step(input int k, input int drv);
    if (!en) begin
      m_hi[k] = 0; m_lo[k] = 0; m_rq[k] = drv; m_dc[k] = int'(dead_cyc);
    end else if (drv != m_rq[k]) begin
      m_hi[k] = 0; m_lo[k] = 0; m_rq[k] = drv; m_dc[k] = int'(dead_cyc);
    end else if (m_dc[k] != 0) begin
      m_hi[k] = 0; m_lo[k] = 0; m_dc[k] = m_dc[k] - 1;
    end else begin
      m_hi[k] = drv; m_lo[k] = 1 - drv;
    end
  endtask

  task automatic model_step();
    int p, hf, sb, hn;
    if (rst) begin
      m_cnt = 0; m_per = 0; m_ph = 0; m_v = 0;
      for (int k = 0; k < 2; k++) begin
        m_rq[k] = 0; m_dc[k] = 0; m_hi[k] = 0; m_lo[k] = 0;
      end
    end else begin
      p  = m_per + 1;
      hf = p / 2;
      sb = (m_cnt + p - m_ph) % p;
      leg_step(0, (m_cnt < hf) ? 1 : 0);
      leg_step(1, (sb < hf) ? 1 : 0);
      if (!en || m_cnt >= m_per) begin
        m_cnt = 0;
        m_per = int'(period_m1);
        hn    = (m_per + 1) / 2;
        m_ph  = min2(min2(int'(dem_cur), int'(dem_volt)), hn);
        m_v   = (dem_volt < dem_cur) ? 1 : 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  endtask

  // One clock: predict with the present inputs, pass the edge, compare.
  task automatic tick();
    model_step();
    @(negedge clk);
    chk("R2 a_hi", int'(a_hi), m_hi[0]);
    chk("R2 a_lo", int'(a_lo), m_lo[0]);
    chk("R3 R6 b_hi", int'(b_hi), m_hi[1]);
    chk("R3 R6 b_lo", int'(b_lo), m_lo[1]);
    chk("R5 volt_in_ctrl", int'(volt_in_ctrl), m_v);
    chk("R7 no overlap", int'((a_hi & a_lo) | (b_hi & b_lo)), 0);
  endtask

  initial begin
    int ov, seg;
    void'($urandom(32'h5eed_0042));
    tick(); tick();
    chk("R1 reset outputs", int'({a_hi, a_lo, b_hi, b_lo, volt_in_ctrl}), 0);
    rst = 1'b0;

    // Full overlap: P=16, phase 8, dead 0 -> 7 overlap cycles per period.
    en = 1'b1; period_m1 = 8'd15; dead_cyc = 4'd0; dem_cur = 8'd8; dem_volt = 8'd20;
    for (int i = 0; i < 40; i++) tick();
    ov = 0;
    for (int i = 0; i < 32; i++) begin tick(); ov += int'(a_hi & b_lo); end
    chk("R4 full overlap count", ov, 14);

    // Demand above half is clamped to half: same overlap.
    dem_cur = 8'd50; dem_volt = 8'd60;
    for (int i = 0; i < 40; i++) tick();
    ov = 0;
    for (int i = 0; i < 32; i++) begin tick(); ov += int'(a_hi & b_lo); end
    chk("R4 clamped overlap count", ov, 14);

    // Zero phase from the voltage loop: no overlap, voltage loop flagged.
    dem_cur = 8'd9; dem_volt = 8'd0;
    for (int i = 0; i < 40; i++) tick();
    chk("R5 voltage wins", int'(volt_in_ctrl), 1);
    ov = 0;
    for (int i = 0; i < 32; i++) begin tick(); ov += int'(a_hi & b_lo); end
    chk("R4 zero overlap count", ov, 0);

    // Tie keeps the current loop in control.
    dem_cur = 8'd3; dem_volt = 8'd3;
    for (int i = 0; i < 40; i++) tick();
    chk("R5 tie current wins", int'(volt_in_ctrl), 0);

    // Disable while driving: all off after one edge.
    dead_cyc = 4'd2;
    for (int i = 0; i < 5; i++) tick();
    en = 1'b0;
    tick();
    chk("R8 disable off", int'({a_hi, a_lo, b_hi, b_lo}), 0);
    for (int i = 0; i < 4; i++) tick();
    en = 1'b1;
    for (int i = 0; i < 30; i++) tick();

    // Random segments, changes not aligned with periods.
    for (int s = 0; s < 250; s++) begin
      period_m1 = 8'($urandom_range(40, 7));
      dead_cyc  = 4'($urandom_range(2, 0));
      dem_cur   = 8'($urandom_range(25, 0));
      dem_volt  = 8'($urandom_range(25, 0));
      en        = ($urandom_range(9, 0) != 0);
      seg = $urandom_range(40, 5);
      for (int i = 0; i < seg; i++) begin
        if (i == seg / 2) begin
          dem_cur  = 8'($urandom_range(25, 0));
          dem_volt = 8'($urandom_range(25, 0));
        end
        tick();
      end
    end

    // Reset in mid-run returns to the reset state.
    rst = 1'b1;
    tick();
    chk("R1 reset mid-run", int'({a_hi, a_lo, b_hi, b_lo, volt_in_ctrl}), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule